// File: doc/BRIEF.md
# Shadowed-Update Pulse Width Modulator

A single-channel pulse width modulator run by one 32-bit configuration word. The word written by software carries an enable, an update request, a frequency step called the base unit, and an inverted on-time divisor. A phase accumulator adds the active base unit on every clock. The output is high while the upper eight accumulator bits are at or above the active divisor. A divisor of 0 therefore gives a continuously high output, and 255 gives a near-zero duty. Software computes the divisor as 255 minus the scaled duty.

The frequency step and the divisor are double-buffered. A write that requests an update loads a shadow copy and raises the update flag. The shadow copy reaches the active settings only at the start of an output cycle, and that can happen only while the channel is enabled. When it does, the flag clears. Software polls the flag before reconfiguring, because a write made while an update is pending leaves every setting unchanged. Turning the channel off takes effect at once. Reset is asserted asynchronously and released through a two-stage synchronizer.

Top module: `pwm_shadowed`

## Requirements
- R1: Word layout: bit 31 is enable, bit 30 is update request, bits [8+BU_W-1:8] are the base unit and bits [7:0] are the divisor. A read returns enable, the live update flag, the shadow base unit and the shadow divisor, with all other bits zero.
- R2: After reset, the read value is zero and the output is low.
- R3: The enable bit is taken from every write. While the update flag is clear, a write loads the shadow base unit and divisor, and sets the flag if bit 30 is 1. While the flag is set, a write changes neither the shadow nor the active settings.
- R4: While the channel is disabled, a set update flag stays set.
- R5: An output cycle starts on the first enabled clock after a disabled one, and on each enabled clock where the accumulator wraps. If the flag is set at such a point, the shadow values become active and the flag reads 0 from the next cycle. At no other time do the active values change.
- R6: The BU_W-bit accumulator is zero while the channel is disabled and during the first enabled clock. After that it adds the active base unit modulo 2^BU_W on each clock, so the output frequency is f_clk × base / 2^BU_W.
- R7: The output is high exactly when the channel is enabled and the upper 8 accumulator bits are greater than or equal to the active divisor. Over 2^BU_W clocks with an odd base unit, the output is high for 2^BU_W − div × 2^(BU_W−8) clocks.
- R8: A write with bit 31 at 0 forces the output low from the next cycle, with no wait for a cycle boundary.
- R9: With an active base unit of zero, the accumulator and the output hold their level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration word |
| wr_data | input | 32 | Configuration word to write |
| rd_data | output | 32 | Configuration word read back, including the live update flag |
| pwm_o | output | 1 | Modulated output |

## Verification
The bench builds the block with BU_W = 10, which makes an output cycle 1024 clocks. With that size, every accumulator value is visited in one pass for any odd base unit. The duty count can then be checked exactly over a sweep of 52 divisors, and the edge count exactly over a sweep of base units up to 511. The short cycle also brings within reach the pending-update corners: a write ignored mid-cycle, a commit delayed until the next wrap, a flag that stays set while disabled, and a zero base unit that freezes the output.

// File: rtl/pwm_shadow_pkg.sv
package pwm_shadow_pkg;
  localparam int EN_POS  = 31;
  localparam int UPD_POS = 30;
  localparam int BU_LSB  = 8;
  localparam int DIV_W   = 8;
endpackage

// File: rtl/pwm_cfg_bank.sv
module pwm_cfg_bank
  import pwm_shadow_pkg::*;
#(
  parameter int BU_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wr_data,
  input  logic             cyc_start,
  output logic             en_o,
  output logic             upd_o,
  output logic [BU_W-1:0]  sh_bu_o,
  output logic [DIV_W-1:0] sh_div_o,
  output logic [BU_W-1:0]  act_bu_o,
  output logic [DIV_W-1:0] act_div_o
);
  logic             en_q, en_d, upd_q, upd_d;
  logic [BU_W-1:0]  sh_bu_q, sh_bu_d, act_bu_q, act_bu_d;
  logic [DIV_W-1:0] sh_div_q, sh_div_d, act_div_q, act_div_d;
  logic             wr_accept, commit;

  assign wr_accept = wr_en && !upd_q;
  assign commit    = upd_q && cyc_start;

  always_comb begin
    en_d      = wr_en ? wr_data[EN_POS] : en_q;
    sh_bu_d   = wr_accept ? wr_data[BU_LSB +: BU_W] : sh_bu_q;
    sh_div_d  = wr_accept ? wr_data[DIV_W-1:0] : sh_div_q;
    upd_d     = upd_q;
    if (commit)                           upd_d = 1'b0;
    else if (wr_accept && wr_data[UPD_POS]) upd_d = 1'b1;
    act_bu_d  = commit ? sh_bu_q  : act_bu_q;
    act_div_d = commit ? sh_div_q : act_div_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      upd_q     <= 1'b0;
      sh_bu_q   <= '0;
      sh_div_q  <= '0;
      act_bu_q  <= '0;
      act_div_q <= '0;
    end else begin
      en_q      <= en_d;
      upd_q     <= upd_d;
      sh_bu_q   <= sh_bu_d;
      sh_div_q  <= sh_div_d;
      act_bu_q  <= act_bu_d;
      act_div_q <= act_div_d;
    end
  end

  assign en_o      = en_q;
  assign upd_o     = upd_q;
  assign sh_bu_o   = sh_bu_q;
  assign sh_div_o  = sh_div_q;
  assign act_bu_o  = act_bu_q;
  assign act_div_o = act_div_q;

  p_busy_write_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && upd_q) |=> ($stable(sh_bu_q) && $stable(sh_div_q)));

  p_pending_held_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && !en_q) |=> upd_q);

  p_active_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_q |=> ($stable(act_bu_q) && $stable(act_div_q)));
endmodule

// File: rtl/pwm_phase.sv
module pwm_phase
  import pwm_shadow_pkg::*;
#(
  parameter int BU_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [BU_W-1:0]  step,
  output logic             cyc_start_o,
  output logic [DIV_W-1:0] top_o
);
  logic [BU_W-1:0] acc_q, acc_d;
  logic            started_q, started_d;
  logic [BU_W:0]   sum;

  assign sum         = {1'b0, acc_q} + {1'b0, step};
  assign cyc_start_o = en && (!started_q || sum[BU_W]);
  assign top_o       = acc_q[BU_W-1 -: DIV_W];

  always_comb begin
    started_d = en;
    acc_d     = (!en || !started_q) ? '0 : sum[BU_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q     <= '0;
      started_q <= 1'b0;
    end else begin
      acc_q     <= acc_d;
      started_q <= started_d;
    end
  end

  p_idle_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (acc_q == '0));

  p_zero_step_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && started_q && step == '0) |=> $stable(acc_q));
endmodule

// File: rtl/pwm_shadowed.sv
module pwm_shadowed
  import pwm_shadow_pkg::*;
#(
  parameter int BU_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  output logic [31:0] rd_data,
  output logic        pwm_o
);
  logic             rst_s1, rst_sync;
  logic             en, upd, cyc_start;
  logic [BU_W-1:0]  sh_bu, act_bu;
  logic [DIV_W-1:0] sh_div, act_div, top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1   <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_s1   <= 1'b1;
      rst_sync <= rst_s1;
    end
  end

  pwm_cfg_bank #(.BU_W(BU_W)) u_cfg (
    .clk(clk), .rst_n(rst_sync), .wr_en(wr_en), .wr_data(wr_data),
    .cyc_start(cyc_start), .en_o(en), .upd_o(upd),
    .sh_bu_o(sh_bu), .sh_div_o(sh_div), .act_bu_o(act_bu), .act_div_o(act_div)
  );

  pwm_phase #(.BU_W(BU_W)) u_phase (
    .clk(clk), .rst_n(rst_sync), .en(en), .step(act_bu),
    .cyc_start_o(cyc_start), .top_o(top)
  );

  always_comb begin
    rd_data                 = '0;
    rd_data[EN_POS]         = en;
    rd_data[UPD_POS]        = upd;
    rd_data[BU_LSB +: BU_W] = sh_bu;
    rd_data[DIV_W-1:0]      = sh_div;
  end

  assign pwm_o = en && (top >= act_div);

  p_disable_prompt_r8: assert property (@(posedge clk) disable iff (!rst_sync)
    (wr_en && !wr_data[EN_POS]) |=> !pwm_o);
endmodule

// File: tb/pwm_shadowed_tb.sv
module pwm_shadowed_tb;
  localparam int BU_W = 10;
  localparam int CYC  = 1 << BU_W;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [31:0] wr_data;
  logic [31:0] rd_data;
  logic        pwm_o;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  pwm_shadowed #(.BU_W(BU_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pwm_o(pwm_o)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [31:0] word(input bit en, input bit upd, input int bu, input int dv);
    logic [31:0] w;
    w = '0;
    w[31] = en;
    w[30] = upd;
    w[8 +: BU_W] = bu[BU_W-1:0];
    w[7:0] = dv[7:0];
    return w;
  endfunction

  task automatic wr(input bit en, input bit upd, input int bu, input int dv);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = word(en, upd, bu, dv);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic start(input int bu, input int dv);
    wr(1'b0, 1'b1, bu, dv);
    wr(1'b1, 1'b0, bu, dv);
    @(negedge clk);
  endtask

  task automatic wait_clear(input string req);
    int n = 0;
    while (rd_data[30] && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(req, int'(n < 3000), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int hi, rises;
    bit prev;
    rst_n = 1'b0;
    wr_en = 1'b0;
    wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    check("R2 read", int'(rd_data), 0);
    check("R2 out", int'(pwm_o), 0);

    // R1 R4 pending held while disabled
    wr(1'b0, 1'b1, 37, 91);
    repeat (40) @(negedge clk);
    check("R1 R4 readback", int'(rd_data), int'(word(1'b0, 1'b1, 37, 91)));
    check("R4 out low", int'(pwm_o), 0);
    // R5 commit on first enabled clock
    wr(1'b1, 1'b0, 37, 91);
    @(negedge clk);
    check("R5 flag clears", int'(rd_data[30]), 0);
    check("R1 enable read", int'(rd_data[31]), 1);
    // R8 immediate disable
    wr(1'b0, 1'b0, 37, 91);
    check("R8 off", int'(pwm_o), 0);

    // R7 duty sweep, odd step
    for (int dv = 0; dv < 256; dv += 5) begin
      start(3, dv);
      hi = 0;
      for (int i = 0; i < CYC; i++) begin
        hi += int'(pwm_o);
        @(negedge clk);
      end
      check($sformatf("R7 duty div=%0d", dv), hi, CYC - dv * (CYC / 256));
      wr(1'b0, 1'b0, 3, dv);
      check("R8 low after off", int'(pwm_o), 0);
    end

    // R6 frequency sweep: rising edges over one full accumulator span
    for (int k = 0; k < 35; k++) begin
      int bu;
      bu = (k < 32) ? k + 1 : (k == 32 ? 100 : (k == 33 ? 255 : 511));
      start(bu, 128);
      rises = 0;
      prev = pwm_o;
      for (int i = 0; i < CYC; i++) begin
        @(negedge clk);
        if (pwm_o && !prev) rises++;
        prev = pwm_o;
      end
      check($sformatf("R6 edges bu=%0d", bu), rises, bu);
      wr(1'b0, 1'b0, bu, 128);
    end

    // R3 R5 pending write ignored, commit waits for wrap
    start(1, 0);
    repeat (5) @(negedge clk);
    wr(1'b1, 1'b1, 1, 200);
    wr(1'b1, 1'b0, 5, 10);
    check("R3 ignored write", int'(rd_data), int'(word(1'b1, 1'b1, 1, 200)));
    repeat (100) @(negedge clk);
    check("R5 still pending", int'(rd_data[30]), 1);
    check("R5 old duty kept", int'(pwm_o), 1);
    wait_clear("R5 commit at wrap");
    hi = 0;
    for (int i = 0; i < CYC; i++) begin
      hi += int'(pwm_o);
      @(negedge clk);
    end
    check("R3 R7 committed duty", hi, CYC - 200 * (CYC / 256));

    // R9 zero step holds level
    wr(1'b1, 1'b1, 0, 0);
    wait_clear("R9 commit");
    @(negedge clk);
    hi = 0;
    for (int i = 0; i < 60; i++) begin
      hi += int'(pwm_o);
      @(negedge clk);
    end
    check("R9 held high", hi, 60);
    wr(1'b0, 1'b0, 0, 0);
    check("R8 final off", int'(pwm_o), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule